// File: doc/BRIEF.md
# Memory Test Traffic Generator

This block walks a memory range, writing a known data pattern and reading it back, then reports one pass/fail word. A host programs it through a single 32-bit configuration stream. The top three bits of each word select a register and the low bits carry that register's data. A start word launches a run. Each step of the run handles one block of words at the current address: the block is written, then each word is read back and compared with what was written. The address then moves on by a programmable increment.

When the address reaches or passes a programmable maximum, a result word is emitted. The result is zero when every compared word matched. Otherwise it is the number of mismatching words. Two options change how a run ends. Halt-on-error stops the run at the first mismatch and reports at once. Loop mode wraps the address back to the base and keeps sweeping until any new configuration word arrives.

The memory side is a simple request port with a ready signal, plus a read response strobe. The block keeps at most one read outstanding.

Top module: `memtest_gen`

## Requirements
- R1: A configuration word is decoded by its bits [31:29]: 1 and 2 load bits [15:0] into the low and high halves of the 32-bit address increment; 3 and 4 do the same for the 32-bit maximum address; 5 loads the block field from bits [3:0]; 6 loads halt-on-error from bit 0; 7 loads loop from bit 0.
- R2: A word with selector 0 and bit 0 set starts a run at base address 0. The same word with bit 0 clear does nothing.
- R3: A block field of n gives n+1 words per request, at byte addresses a, a+4, … . Each word is written with data (address XOR 32'h5A5A_C3C3). The words are then read back in the same order, and a read is issued only after the previous read's response.
- R4: Requests are made at base, base+inc, base+2·inc, … while the address is below the maximum (unsigned). A sum that carries past 32 bits ends the sweep.
- R5: At the end of a non-looping sweep, res_valid pulses for exactly one cycle with res_data equal to the mismatch count (saturating), so zero means pass. A maximum not above the base yields an immediate pass with no requests.
- R6: With halt-on-error set, the run stops at the first mismatching read and reports a count of 1. No further request is made.
- R7: With halt-on-error clear, every address in range is visited and every mismatch is counted.
- R8: With loop set, the address wraps to the base after the last step and the sweep continues. No result is sent unless a halting error ends the run.
- R9: While a run is active, configuration words change no register and a start word is ignored. In loop mode, any configuration word ends the run after the current request completes, with no result.
- R10: A request held without req_ready keeps its valid, address, direction and data unchanged.
- R11: Reset leaves the block idle with no request and no result. Reset values are an increment of 4, a maximum of 0, a block field of 0, and both options clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_valid | input | 1 | Configuration word present |
| cfg_data | input | 32 | Configuration word: selector [31:29], data below |
| res_valid | output | 1 | One-cycle result strobe |
| res_data | output | 32 | Mismatch count, zero on pass |
| req_valid | output | 1 | Memory request valid |
| req_ready | input | 1 | Memory accepts request |
| req_write | output | 1 | 1 = write, 0 = read |
| req_addr | output | 32 | Byte address of the word |
| req_wdata | output | 32 | Write data |
| rsp_valid | input | 1 | Read response strobe |
| rsp_rdata | input | 32 | Read response data |

## Verification
The assertions take for granted that the memory returns a read response only while the block is waiting for one, and never more than one per read. They also assume the increment is non-zero whenever the address advances. The bench memory model answers each accepted read exactly one cycle later. It toggles req_ready only from its own clocked register, and every test programs a non-zero increment. Configuration words are sent mid-run only in the tests aimed at R9, so that the register-stability property has a real case to cover.

// File: rtl/memtest_pkg.sv
package memtest_pkg;

   typedef enum logic [2:0] {
      S_IDLE,
      S_CHK,
      S_WR,
      S_RREQ,
      S_RWAIT,
      S_REP
   } seq_state_t;

   localparam logic [2:0] SEL_START  = 3'd0;
   localparam logic [2:0] SEL_INC_LO = 3'd1;
   localparam logic [2:0] SEL_INC_HI = 3'd2;
   localparam logic [2:0] SEL_MAX_LO = 3'd3;
   localparam logic [2:0] SEL_MAX_HI = 3'd4;
   localparam logic [2:0] SEL_BLOCK  = 3'd5;
   localparam logic [2:0] SEL_HALT   = 3'd6;
   localparam logic [2:0] SEL_LOOP   = 3'd7;

endpackage

// File: rtl/memtest_cfg_regs.sv
module memtest_cfg_regs
   import memtest_pkg::*;
#(
   parameter int          CFG_W   = 32,
   parameter int          SEL_W   = 3,
   parameter int          ADDR_W  = 32,
   parameter int          BLK_W   = 4,
   parameter logic [31:0] INC_RST = 32'd4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_valid,
   input  logic [CFG_W-1:0]  cfg_data,
   input  logic              busy,
   output logic              start_o,
   output logic [ADDR_W-1:0] inc_o,
   output logic [ADDR_W-1:0] max_o,
   output logic [BLK_W-1:0]  blk_o,
   output logic              halt_o,
   output logic              loop_o
);

   localparam int HALF_W = ADDR_W / 2;

   generate
      if (SEL_W != 3) begin : g_bad_sel
         $error("memtest_cfg_regs: selector must be 3 bits");
      end
      if (CFG_W - SEL_W <= HALF_W) begin : g_bad_cfg
         $error("memtest_cfg_regs: data field narrower than half address");
      end
      if (BLK_W > HALF_W) begin : g_bad_blk
         $error("memtest_cfg_regs: block field too wide");
      end
   endgenerate

   logic [SEL_W-1:0]  sel;
   logic [HALF_W-1:0] half;
   logic              wr_en;
   logic              cfg_unused;

   logic [ADDR_W-1:0] inc_q, max_q;
   logic [BLK_W-1:0]  blk_q;
   logic              halt_q, loop_q;

   assign sel        = cfg_data[CFG_W-1 -: SEL_W];
   assign half       = cfg_data[HALF_W-1:0];
   assign wr_en      = cfg_valid && !busy;
   assign cfg_unused = ^cfg_data[CFG_W-SEL_W-1:HALF_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         inc_q  <= INC_RST[ADDR_W-1:0];
         max_q  <= '0;
         blk_q  <= '0;
         halt_q <= 1'b0;
         loop_q <= 1'b0;
      end else if (wr_en) begin
         case (sel)
            SEL_INC_LO: inc_q[HALF_W-1:0]      <= half;
            SEL_INC_HI: inc_q[ADDR_W-1:HALF_W] <= half;
            SEL_MAX_LO: max_q[HALF_W-1:0]      <= half;
            SEL_MAX_HI: max_q[ADDR_W-1:HALF_W] <= half;
            SEL_BLOCK:  blk_q                  <= half[BLK_W-1:0];
            SEL_HALT:   halt_q                 <= half[0];
            SEL_LOOP:   loop_q                 <= half[0];
            default:    ;
         endcase
      end
   end

   assign start_o = wr_en && (sel == SEL_START) && half[0];
   assign inc_o   = inc_q;
   assign max_o   = max_q;
   assign blk_o   = blk_q;
   assign halt_o  = halt_q;
   assign loop_o  = loop_q;

   // R9
   regs_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> ($stable(inc_q) && $stable(max_q) && $stable(blk_q)
                && $stable(halt_q) && $stable(loop_q)));

endmodule

// File: rtl/memtest_addr_walk.sv
module memtest_addr_walk #(
   parameter int                ADDR_W    = 32,
   parameter logic [ADDR_W-1:0] BASE_ADDR = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              init,
   input  logic              adv,
   input  logic [ADDR_W-1:0] inc,
   input  logic [ADDR_W-1:0] max_addr,
   output logic [ADDR_W-1:0] addr_o,
   output logic              at_end
);

   generate
      if (ADDR_W < 8) begin : g_bad_w
         $error("memtest_addr_walk: address too narrow");
      end
   endgenerate

   // One extra bit keeps the carry so a wrapped sum still counts as past the end
   logic [ADDR_W:0] cur_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cur_q <= '0;
      else if (init)
         cur_q <= {1'b0, BASE_ADDR};
      else if (adv)
         cur_q <= cur_q + {1'b0, inc};
   end

   assign at_end = cur_q >= {1'b0, max_addr};
   assign addr_o = cur_q[ADDR_W-1:0];

   // R4
   addr_rises_chk: assert property (@(posedge clk) disable iff (!rst_n)
      adv |=> ((cur_q > $past(cur_q)) || ($past(inc) == '0)));

endmodule

// File: rtl/memtest_seq.sv
module memtest_seq
   import memtest_pkg::*;
#(
   parameter int               ADDR_W   = 32,
   parameter int               DATA_W   = 32,
   parameter int               BLK_W    = 4,
   parameter int               RES_W    = 32,
   parameter bit               ERR_SAT  = 1'b1,
   parameter logic [DATA_W-1:0] PAT_SEED = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              cfg_valid,
   input  logic [BLK_W-1:0]  blk,
   input  logic              halt,
   input  logic              loop,
   input  logic [ADDR_W-1:0] addr,
   input  logic              at_end,
   output logic              walk_init,
   output logic              walk_adv,
   output logic              busy,
   output logic              req_valid,
   input  logic              req_ready,
   output logic              req_write,
   output logic [ADDR_W-1:0] req_addr,
   output logic [DATA_W-1:0] req_wdata,
   input  logic              rsp_valid,
   input  logic [DATA_W-1:0] rsp_rdata,
   output logic              res_valid,
   output logic [RES_W-1:0]  res_data
);

   localparam int WB_SH = $clog2(DATA_W / 8);

   generate
      if (DATA_W != ADDR_W) begin : g_bad_dw
         $error("memtest_seq: data pattern needs data width equal to address width");
      end
      if (DATA_W % 8 != 0) begin : g_bad_bytes
         $error("memtest_seq: data width must be whole bytes");
      end
   endgenerate

   seq_state_t        state_q;
   logic [BLK_W-1:0]  beat_q;
   logic [RES_W-1:0]  err_q, err_nxt;
   logic              abort_q;
   logic              last_beat;
   logic [DATA_W-1:0] exp_word;
   logic              mismatch;

   generate
      if (ERR_SAT) begin : g_sat
         assign err_nxt = (&err_q) ? err_q : err_q + 1'b1;
      end else begin : g_wrap
         assign err_nxt = err_q + 1'b1;
      end
   endgenerate

   assign last_beat = beat_q == blk;
   assign req_addr  = addr + (ADDR_W'(beat_q) << WB_SH);
   assign exp_word  = DATA_W'(req_addr) ^ PAT_SEED;
   assign mismatch  = rsp_rdata != exp_word;

   assign req_valid = (state_q == S_WR) || (state_q == S_RREQ);
   assign req_write = state_q == S_WR;
   assign req_wdata = exp_word;
   assign res_valid = state_q == S_REP;
   assign res_data  = err_q;
   assign busy      = state_q != S_IDLE;

   assign walk_init = ((state_q == S_IDLE) && start) ||
                      ((state_q == S_CHK) && !abort_q && at_end && loop);
   assign walk_adv  = (state_q == S_RWAIT) && rsp_valid && last_beat &&
                      !(mismatch && halt);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= S_IDLE;
         beat_q  <= '0;
         err_q   <= '0;
         abort_q <= 1'b0;
      end else begin
         if (state_q == S_IDLE)
            abort_q <= 1'b0;
         else if (cfg_valid && loop)
            abort_q <= 1'b1;

         case (state_q)
            S_IDLE: begin
               if (start) begin
                  state_q <= S_CHK;
                  beat_q  <= '0;
                  err_q   <= '0;
               end
            end
            S_CHK: begin
               if (abort_q)
                  state_q <= S_IDLE;
               else if (at_end) begin
                  if (!loop)
                     state_q <= S_REP;
               end else
                  state_q <= S_WR;
            end
            S_WR: begin
               if (req_ready) begin
                  if (last_beat) begin
                     beat_q  <= '0;
                     state_q <= S_RREQ;
                  end else
                     beat_q <= beat_q + 1'b1;
               end
            end
            S_RREQ: begin
               if (req_ready)
                  state_q <= S_RWAIT;
            end
            S_RWAIT: begin
               if (rsp_valid) begin
                  if (mismatch)
                     err_q <= err_nxt;
                  if (mismatch && halt)
                     state_q <= S_REP;
                  else if (last_beat) begin
                     beat_q  <= '0;
                     state_q <= S_CHK;
                  end else begin
                     beat_q  <= beat_q + 1'b1;
                     state_q <= S_RREQ;
                  end
               end
            end
            S_REP:   state_q <= S_IDLE;
            default: state_q <= S_IDLE;
         endcase
      end
   end

   // R5
   res_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |=> !res_valid);

   // R10
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_ready) |=> (req_valid && $stable(req_addr)
                                     && $stable(req_write) && $stable(req_wdata)));

   // R3
   rsp_expected_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (state_q == S_RWAIT));

   // R6
   halt_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |=> !req_valid);

endmodule

// File: rtl/memtest_gen.sv
module memtest_gen #(
   parameter int          ADDR_W    = 32,
   parameter int          DATA_W    = 32,
   parameter int          CFG_W     = 32,
   parameter int          BLK_W     = 4,
   parameter int          RES_W     = 32,
   parameter bit          ERR_SAT   = 1'b1,
   parameter logic [31:0] BASE_ADDR = 32'h0,
   parameter logic [31:0] INC_RST   = 32'd4,
   parameter logic [31:0] PAT_SEED  = 32'h5A5A_C3C3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_valid,
   input  logic [CFG_W-1:0]  cfg_data,
   output logic              res_valid,
   output logic [RES_W-1:0]  res_data,
   output logic              req_valid,
   input  logic              req_ready,
   output logic              req_write,
   output logic [ADDR_W-1:0] req_addr,
   output logic [DATA_W-1:0] req_wdata,
   input  logic              rsp_valid,
   input  logic [DATA_W-1:0] rsp_rdata
);

   localparam int SEL_W = 3;

   generate
      if (ADDR_W % 2 != 0) begin : g_bad_addr
         $error("memtest_gen: address width must be even");
      end
      if (ADDR_W > 32 || DATA_W > 32) begin : g_bad_wide
         $error("memtest_gen: widths above 32 bits are not supported");
      end
   endgenerate

   logic              start;
   logic              busy;
   logic [ADDR_W-1:0] inc, max_addr, walk_addr;
   logic [BLK_W-1:0]  blk;
   logic              halt, loop;
   logic              walk_init, walk_adv, at_end;

   memtest_cfg_regs #(
      .CFG_W   (CFG_W),
      .SEL_W   (SEL_W),
      .ADDR_W  (ADDR_W),
      .BLK_W   (BLK_W),
      .INC_RST (INC_RST)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_valid (cfg_valid),
      .cfg_data  (cfg_data),
      .busy      (busy),
      .start_o   (start),
      .inc_o     (inc),
      .max_o     (max_addr),
      .blk_o     (blk),
      .halt_o    (halt),
      .loop_o    (loop)
   );

   memtest_addr_walk #(
      .ADDR_W    (ADDR_W),
      .BASE_ADDR (BASE_ADDR[ADDR_W-1:0])
   ) u_walk (
      .clk      (clk),
      .rst_n    (rst_n),
      .init     (walk_init),
      .adv      (walk_adv),
      .inc      (inc),
      .max_addr (max_addr),
      .addr_o   (walk_addr),
      .at_end   (at_end)
   );

   memtest_seq #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .BLK_W    (BLK_W),
      .RES_W    (RES_W),
      .ERR_SAT  (ERR_SAT),
      .PAT_SEED (PAT_SEED[DATA_W-1:0])
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .cfg_valid (cfg_valid),
      .blk       (blk),
      .halt      (halt),
      .loop      (loop),
      .addr      (walk_addr),
      .at_end    (at_end),
      .walk_init (walk_init),
      .walk_adv  (walk_adv),
      .busy      (busy),
      .req_valid (req_valid),
      .req_ready (req_ready),
      .req_write (req_write),
      .req_addr  (req_addr),
      .req_wdata (req_wdata),
      .rsp_valid (rsp_valid),
      .rsp_rdata (rsp_rdata),
      .res_valid (res_valid),
      .res_data  (res_data)
   );

endmodule

// File: tb/memtest_gen_tb.sv
module memtest_gen_tb;

   localparam int          CLK_P = 10;
   localparam logic [31:0] SEED  = 32'h5A5A_C3C3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_valid = 1'b0;
   logic [31:0] cfg_data = '0;
   logic        res_valid;
   logic [31:0] res_data;
   logic        req_valid, req_write;
   logic        req_ready;
   logic [31:0] req_addr, req_wdata;
   logic        rsp_valid = 1'b0;
   logic [31:0] rsp_rdata = '0;

   always #(CLK_P/2) clk = ~clk;

   memtest_gen u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_valid (cfg_valid),
      .cfg_data  (cfg_data),
      .res_valid (res_valid),
      .res_data  (res_data),
      .req_valid (req_valid),
      .req_ready (req_ready),
      .req_write (req_write),
      .req_addr  (req_addr),
      .req_wdata (req_wdata),
      .rsp_valid (rsp_valid),
      .rsp_rdata (rsp_rdata)
   );

   int n_chk = 0;
   int n_err = 0;

   // memory model
   logic [31:0] mem [0:255];
   logic        bp_en = 1'b0;
   logic [3:0]  rdy_cnt = '0;
   logic        rdy_q = 1'b1;
   logic        fault_en = 1'b0;
   logic [31:0] fault_a = '0, fault_b = '0;

   assign req_ready = rdy_q;

   always @(posedge clk) begin
      rdy_cnt   <= rdy_cnt + 1'b1;
      rdy_q     <= bp_en ? (rdy_cnt[1:0] == 2'd3) : 1'b1;
      rsp_valid <= 1'b0;
      if (req_valid && req_ready) begin
         if (req_write)
            mem[req_addr[9:2]] <= req_wdata;
         else begin
            rsp_valid <= 1'b1;
            rsp_rdata <= mem[req_addr[9:2]] ^
               ((fault_en && (req_addr == fault_a || req_addr == fault_b)) ? 32'h1 : 32'h0);
         end
      end
   end

   // monitor
   int          wr_cnt = 0, rd_cnt = 0, wr0_cnt = 0, res_cnt = 0;
   logic [31:0] last_wr = '0, last_res = '0;
   logic        rd_pend = 1'b0;
   logic        prev_stall = 1'b0;
   logic [31:0] prev_addr = '0;
   logic        prev_wr = 1'b0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (rsp_valid) rd_pend = 1'b0;
         if (prev_stall) begin
            n_chk++;
            if (!(req_valid && req_addr == prev_addr && req_write == prev_wr)) begin
               n_err++;
               $display("FAIL R10: held request changed, actual addr=%0h expected=%0h", req_addr, prev_addr);
            end
         end
         if (req_valid && req_ready) begin
            if (req_write) begin
               wr_cnt++;
               last_wr = req_addr;
               if (req_addr == 32'h0) wr0_cnt++;
               n_chk++;
               if (req_wdata !== (req_addr ^ SEED)) begin
                  n_err++;
                  $display("FAIL R3: write data actual=%0h expected=%0h", req_wdata, req_addr ^ SEED);
               end
            end else begin
               rd_cnt++;
               n_chk++;
               if (rd_pend) begin
                  n_err++;
                  $display("FAIL R3: read issued with read outstanding, actual=1 expected=0");
               end
               rd_pend = 1'b1;
            end
         end
         if (res_valid) begin
            res_cnt++;
            last_res = res_data;
         end
         prev_stall = req_valid && !req_ready;
         prev_addr  = req_addr;
         prev_wr    = req_write;
      end
   end

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic cfg(input logic [2:0] sel, input logic [15:0] d);
      @(negedge clk);
      cfg_valid = 1'b1;
      cfg_data  = {sel, 13'h0, d};
      @(negedge clk);
      cfg_valid = 1'b0;
      cfg_data  = '0;
   endtask

   task automatic setup(input logic [31:0] inc, input logic [31:0] mx,
                        input logic [3:0] blk, input bit halt, input bit lp);
      cfg(3'd1, inc[15:0]);
      cfg(3'd2, inc[31:16]);
      cfg(3'd3, mx[15:0]);
      cfg(3'd4, mx[31:16]);
      cfg(3'd5, {12'h0, blk});
      cfg(3'd6, {15'h0, halt});
      cfg(3'd7, {15'h0, lp});
   endtask

   task automatic clear_counts();
      @(negedge clk);
      wr_cnt = 0; rd_cnt = 0; wr0_cnt = 0; res_cnt = 0; last_wr = '0; last_res = '0;
   endtask

   task automatic run_wait(input string tag);
      int t;
      clear_counts();
      cfg(3'd0, 16'h1);
      t = 0;
      while (res_cnt == 0 && t < 5000) begin
         @(negedge clk);
         t++;
      end
      chk(res_cnt == 1, tag, res_cnt, 1);
      repeat (4) @(negedge clk);
   endtask

   task automatic t_reset();
      chk(!req_valid, "R11", req_valid, 0);
      chk(!res_valid, "R11", res_valid, 0);
      // reset max of 0: start gives an immediate pass with no requests
      run_wait("R5");
      chk(last_res == 0, "R5", last_res, 0);
      chk(wr_cnt == 0, "R11", wr_cnt, 0);
   endtask

   task automatic t_noop_start();
      clear_counts();
      cfg(3'd0, 16'h0);
      repeat (20) @(negedge clk);
      chk(res_cnt == 0 && wr_cnt == 0, "R2", res_cnt + wr_cnt, 0);
   endtask

   task automatic t_basic();
      setup(32'd16, 32'd64, 4'd1, 1'b0, 1'b0);
      run_wait("R2");
      chk(last_res == 0, "R5", last_res, 0);
      chk(wr_cnt == 8, "R3", wr_cnt, 8);
      chk(rd_cnt == 8, "R3", rd_cnt, 8);
      chk(last_wr == 32'd52, "R4", last_wr, 52);
   endtask

   task automatic t_halves();
      setup(32'h0001_0000, 32'h0003_0000, 4'd0, 1'b0, 1'b0);
      run_wait("R1");
      chk(wr_cnt == 3, "R1", wr_cnt, 3);
      chk(last_wr == 32'h0002_0000, "R1", last_wr, 32'h0002_0000);
   endtask

   task automatic t_errors();
      setup(32'd16, 32'd64, 4'd1, 1'b0, 1'b0);
      fault_a = 32'h14; fault_b = 32'h24; fault_en = 1'b1;
      run_wait("R7");
      fault_en = 1'b0;
      chk(last_res == 2, "R7", last_res, 2);
      chk(rd_cnt == 8, "R7", rd_cnt, 8);
   endtask

   task automatic t_halt();
      setup(32'd16, 32'd64, 4'd1, 1'b1, 1'b0);
      fault_a = 32'h14; fault_b = 32'h14; fault_en = 1'b1;
      run_wait("R6");
      fault_en = 1'b0;
      chk(last_res == 1, "R6", last_res, 1);
      chk(rd_cnt == 4, "R6", rd_cnt, 4);
      chk(wr_cnt == 4, "R6", wr_cnt, 4);
   endtask

   task automatic t_overflow();
      setup(32'hC000_0000, 32'hFFFF_FFFF, 4'd0, 1'b0, 1'b0);
      run_wait("R4");
      chk(wr_cnt == 2, "R4", wr_cnt, 2);
      chk(last_wr == 32'hC000_0000, "R4", last_wr, 32'hC000_0000);
      chk(last_res == 0, "R4", last_res, 0);
   endtask

   task automatic t_busy_ignore();
      int t;
      setup(32'd16, 32'd64, 4'd1, 1'b0, 1'b0);
      bp_en = 1'b1;
      clear_counts();
      cfg(3'd0, 16'h1);
      repeat (3) @(negedge clk);
      cfg(3'd1, 16'd4);
      cfg(3'd0, 16'h1);
      t = 0;
      while (res_cnt == 0 && t < 5000) begin
         @(negedge clk);
         t++;
      end
      repeat (100) @(negedge clk);
      chk(res_cnt == 1, "R9", res_cnt, 1);
      chk(wr_cnt == 8, "R9", wr_cnt, 8);
      // increment written during the run must not have taken effect
      run_wait("R9");
      chk(wr_cnt == 8 && last_wr == 32'd52, "R9", last_wr, 52);
      bp_en = 1'b0;
   endtask

   task automatic t_loop_abort();
      int t, snap;
      setup(32'd16, 32'd32, 4'd0, 1'b0, 1'b1);
      clear_counts();
      cfg(3'd0, 16'h1);
      t = 0;
      while (wr0_cnt < 2 && t < 5000) begin
         @(negedge clk);
         t++;
      end
      chk(wr0_cnt >= 2, "R8", wr0_cnt, 2);
      cfg(3'd7, 16'h0);
      repeat (40) @(negedge clk);
      snap = wr_cnt;
      repeat (40) @(negedge clk);
      chk(wr_cnt == snap, "R9", wr_cnt, snap);
      chk(res_cnt == 0, "R8", res_cnt, 0);
      chk(rd_cnt == wr_cnt, "R9", rd_cnt, wr_cnt);
   endtask

   task automatic t_loop_halt();
      setup(32'd16, 32'd32, 4'd0, 1'b1, 1'b1);
      fault_a = 32'h10; fault_b = 32'h10; fault_en = 1'b1;
      run_wait("R8");
      fault_en = 1'b0;
      chk(last_res == 1, "R8", last_res, 1);
      chk(rd_cnt == 2, "R6", rd_cnt, 2);
      setup(32'd16, 32'd32, 4'd0, 1'b0, 1'b0);
   endtask

   task automatic t_backpressure();
      setup(32'd8, 32'd40, 4'd2, 1'b0, 1'b0);
      bp_en = 1'b1;
      run_wait("R10");
      bp_en = 1'b0;
      chk(wr_cnt == 15, "R10", wr_cnt, 15);
      chk(last_res == 0, "R10", last_res, 0);
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=expired expected=finished");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_noop_start();
      t_basic();
      t_halves();
      t_errors();
      t_halt();
      t_overflow();
      t_busy_ignore();
      t_loop_abort();
      t_loop_halt();
      t_backpressure();
      finish_run();
   end

endmodule